// File: doc/BRIEF.md
# Serial Port Interrupt Flag Controller

This block holds the interrupt state of a serial port with four event sources: start of a receive frame, end of a receive frame, end of a transmit frame, and the transmit data holding register running empty. The serial datapath reports each event as a one-cycle condition pulse. The block latches each pulse into its own flag bit and keeps a per-source enable mask. It drives one shared request line. Software reads the flag register to find out which source raised it.

Software reaches the block through a small synchronous register port with a word address. The enable mask has no plain write path. One address turns bits on, another turns them off, and both addresses read back the current mask. Flags are cleared by writing ones to the flag address. A condition pulse that lands in the same cycle as a clear of that bit wins, so no event is lost.

Top module: `sif_irq_ctrl`

## Requirements
- R1: Bit positions in the flag vector, the enable vector and every data word are fixed: bit 0 = receive start, bit 1 = receive complete, bit 2 = transmit complete, bit 3 = data-register empty.
- R2: A condition pulse sets its flag on the next clock edge whether or not that source is enabled. The flag then holds until it is cleared or reset.
- R3: At address 0 a read returns the flag vector. A write there clears every flag whose data bit is 1 and leaves the flags at 0 bits unchanged.
- R4: When a condition pulse and a clear of the same flag happen in the same cycle, the flag ends up set.
- R5: A write to address 1 sets each enable bit whose data bit is 1. Enable bits at 0 in the data keep their value.
- R6: A write to address 2 clears each enable bit whose data bit is 1. Enable bits at 0 in the data keep their value.
- R7: A read of address 1 or address 2 returns the current enable mask. Address 3 always reads zero, and writes to it change no state.
- R8: `irq_o` is high exactly when at least one source has both its flag and its enable set. It is driven from the registered state with no further delay.
- R9: Once high, `irq_o` stays high until every flagged source is either cleared or disabled, or until reset.
- R10: Synchronous active-high reset clears all flags and all enables. `irq_o` is therefore low on the edge after reset is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 4 | Write data, one bit per source |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 4 | Read data, combinational from the addressed register |
| cond_i | input | 4 | Per-source condition pulses from the datapath |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every write and every condition pulse takes effect at the clock edge that samples it. Both `rd_data` and `irq_o` follow the registered state combinationally, so each stimulus has its result due in the same cycle just after that edge. The driver applies inputs on the falling edge, updates its own model for the coming rising edge and queues the expected read word and request level. The monitor pops one item shortly after each rising edge and compares it, which keeps every comparison exactly one edge behind its stimulus.

// File: rtl/sif_pkg.sv
package sif_pkg;

    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned ADDR_W  = 2;

    typedef enum logic [1:0] {
        SRC_RX_START = 2'd0,
        SRC_RX_DONE  = 2'd1,
        SRC_TX_DONE  = 2'd2,
        SRC_TX_EMPTY = 2'd3
    } src_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAGS  = 2'd0,
        REG_EN_SET = 2'd1,
        REG_EN_CLR = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t flag_clr;
        src_vec_t en_set;
        src_vec_t en_clr;
    } wr_strobe_t;

    function automatic logic is_mask_addr(input logic [ADDR_W-1:0] a);
        return (a == REG_EN_SET) || (a == REG_EN_CLR);
    endfunction

endpackage

// File: rtl/sif_reg_decode.sv
module sif_reg_decode
    import sif_pkg::*;
#(
    parameter int unsigned N  = NUM_SRC,
    parameter int unsigned AW = ADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [N-1:0]   wr_data,
    input  logic [AW-1:0]  rd_addr,
    input  logic [N-1:0]   flags,
    input  logic [N-1:0]   mask,
    output wr_strobe_t     strobe,
    output logic [N-1:0]   rd_data
);

    always_comb begin
        strobe = '0;
        if (wr_en) begin
            case (wr_addr)
                REG_FLAGS:  strobe.flag_clr = wr_data;
                REG_EN_SET: strobe.en_set   = wr_data;
                REG_EN_CLR: strobe.en_clr   = wr_data;
                default:    strobe          = '0;
            endcase
        end
    end

    always_comb begin
        if (rd_addr == REG_FLAGS)
            rd_data = flags;
        else if (is_mask_addr(rd_addr))
            rd_data = mask;
        else
            rd_data = '0;
    end

    assert_spare_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == REG_NONE) |-> (rd_data == '0));

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        $countones({|strobe.flag_clr, |strobe.en_set, |strobe.en_clr}) <= 1);

endmodule

// File: rtl/sif_flag_bank.sv
module sif_flag_bank
    import sif_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (cond[i])
                flags[i] <= 1'b1;
            else if (clr[i])
                flags[i] <= 1'b0;
        end
    end

    assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (|cond) |=> ((flags & $past(cond)) == $past(cond)));

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (|(cond & clr)) |=> ((flags & $past(cond & clr)) == $past(cond & clr)));

    assert_clear_only_ones_R3: assert property (@(posedge clk) disable iff (rst)
        (cond == '0) |=> (flags == ($past(flags) & ~$past(clr))));

    assert_reset_flags_R10: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0));

endmodule

// File: rtl/sif_enable_mask.sv
module sif_enable_mask
    import sif_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_bits,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] mask
);

    for (genvar i = 0; i < N; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst)
                mask[i] <= 1'b0;
            else if (set_bits[i])
                mask[i] <= 1'b1;
            else if (clr_bits[i])
                mask[i] <= 1'b0;
        end
    end

    assert_set_enables_R5: assert property (@(posedge clk) disable iff (rst)
        (|set_bits) |=> ((mask & $past(set_bits)) == $past(set_bits)));

    assert_clear_disables_R6: assert property (@(posedge clk) disable iff (rst)
        (|clr_bits && set_bits == '0) |=> ((mask & $past(clr_bits)) == '0));

    assert_zero_bits_hold_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((mask & ~$past(set_bits | clr_bits)) ==
                  ($past(mask) & ~$past(set_bits | clr_bits))));

    assert_reset_mask_R10: assert property (@(posedge clk)
        $past(rst) |-> (mask == '0));

endmodule

// File: rtl/sif_irq_ctrl.sv
module sif_irq_ctrl
    import sif_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [NUM_SRC-1:0]  wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [NUM_SRC-1:0]  rd_data,
    input  logic [NUM_SRC-1:0]  cond_i,
    output logic                irq_o
);

    src_vec_t   flags;
    src_vec_t   mask;
    wr_strobe_t strobe;

    sif_reg_decode #(.N(NUM_SRC), .AW(ADDR_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .flags   (flags),
        .mask    (mask),
        .strobe  (strobe),
        .rd_data (rd_data)
    );

    sif_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .cond  (cond_i),
        .clr   (strobe.flag_clr),
        .flags (flags)
    );

    sif_enable_mask #(.N(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .set_bits (strobe.en_set),
        .clr_bits (strobe.en_clr),
        .mask     (mask)
    );

    assign irq_o = |(flags & mask);

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(|cond_i) ||
                          ($past(wr_en) && $past(wr_addr) == REG_EN_SET)));

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !wr_en) |=> irq_o);

    assert_reset_irq_R10: assert property (@(posedge clk)
        $past(rst) |-> !irq_o);

endmodule

// File: tb/sim_sif_irq_ctrl.sv
module sim_sif_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [3:0] rd_data;
    logic [3:0] cond_i = '0;
    logic       irq_o;

    always #10 clk = ~clk;

    sif_irq_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cond_i(cond_i), .irq_o(irq_o)
    );

    typedef struct {
        logic [3:0] rd_exp;
        logic       irq_exp;
        string      tag;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] m_flags = '0;
    logic [3:0] m_en = '0;
    bit done = 0;

    // Driver: drive on the falling edge, predict the state after the next rising edge.
    task automatic step(input logic r, input logic we, input logic [1:0] wa,
                        input logic [3:0] wd, input logic [3:0] c,
                        input logic [1:0] ra, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd; cond_i = c; rd_addr = ra;
        if (r) begin
            m_flags = '0; m_en = '0;
        end else begin
            m_flags = (we && wa == 2'd0) ? ((m_flags & ~wd) | c) : (m_flags | c);
            if (we && wa == 2'd1) m_en = m_en | wd;
            if (we && wa == 2'd2) m_en = m_en & ~wd;
        end
        e.rd_exp  = (ra == 2'd0) ? m_flags : (ra == 2'd3) ? 4'b0 : m_en;
        e.irq_exp = |(m_flags & m_en);
        e.tag     = tag;
        q.push_back(e);
    endtask

    task automatic idle(input logic [1:0] ra, input string tag);
        step(1'b0, 1'b0, 2'd0, 4'h0, 4'h0, ra, tag);
    endtask

    // Monitor: compare just after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_cmp++;
            if (rd_data !== e.rd_exp) begin
                n_bad++;
                $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.rd_exp);
            end
            n_cmp++;
            if (irq_o !== e.irq_exp) begin
                n_bad++;
                $display("FAIL %s irq_o actual=%b expected=%b", e.tag, irq_o, e.irq_exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(1, 0, 0, 0, 0, 0, "R10 reset");
        step(1, 0, 0, 0, 0, 1, "R10 reset mask");
        idle(2'd0, "R10 flags zero after reset");
        // R2 R1: flags set with enables off
        step(0, 0, 0, 0, 4'b0101, 0, "R2 set rx_start+tx_done");
        idle(2'd0, "R2 flags hold");
        idle(2'd1, "R7 mask read at set addr");
        // R5 R8
        step(0, 1, 1, 4'b0100, 0, 2, "R5 enable tx_done");
        step(0, 1, 1, 4'b0000, 0, 1, "R5 zero set write");
        idle(2'd2, "R9 irq holds");
        idle(2'd0, "R9 irq holds 2");
        // R3
        step(0, 1, 0, 4'b0000, 0, 0, "R3 zero clear write");
        step(0, 1, 0, 4'b0100, 0, 0, "R3 clear tx_done");
        // R4
        step(0, 1, 0, 4'b0100, 4'b0100, 0, "R4 set beats clear");
        // R6
        step(0, 1, 2, 4'b0000, 0, 1, "R6 zero clear-enable write");
        step(0, 1, 2, 4'b0100, 0, 2, "R6 disable tx_done");
        step(0, 0, 0, 0, 0, 0, "R6 flag remains");
        // R7 spare address
        step(0, 1, 3, 4'b1111, 0, 3, "R7 spare reads zero");
        idle(2'd1, "R7 spare write ignored mask");
        idle(2'd0, "R7 spare write ignored flags");
        // R1: each source alone
        step(0, 1, 0, 4'b1111, 0, 0, "R1 clear all");
        for (int i = 0; i < 4; i++) begin
            step(0, 1, 1, 4'b0001 << i, 0, 1, "R1 enable one");
            step(0, 0, 0, 0, 4'b0001 << i, 0, "R1 pulse one");
            step(0, 1, 0, 4'b0001 << i, 0, 0, "R1 clear one");
            step(0, 1, 2, 4'b1111, 0, 2, "R1 disable all");
        end
        // R8: flag without enable gives no irq, then enable on other bit
        step(0, 0, 0, 0, 4'b1000, 0, "R8 flag no enable");
        step(0, 1, 1, 4'b0010, 0, 1, "R8 unrelated enable");
        step(0, 1, 1, 4'b1000, 0, 0, "R8 matching enable");
        // R10 / R9: reset drops irq
        step(1, 0, 0, 0, 0, 0, "R10 reset drops irq");
        idle(2'd1, "R10 mask cleared");
        idle(2'd0, "R10 flags cleared");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule